// File: doc/BRIEF.md
# Transmit DMA Channel Arbiter

This block chooses which packet channel's transmit queue the DMA engine serves next when fetching outgoing data from host memory. Every channel raises one bit of a request vector; the block answers with a registered one-hot grant and a grant-valid flag, and it holds that answer until the consumer acknowledges it with a one-cycle accept pulse.

A 2-bit mode input splits the channels into two classes. The lowest-numbered channels of a mode-dependent group size are served by strict fixed priority, and every channel above that group shares the DMA fairly through a rotating pointer. Any request from the fixed group beats all requests from the rotating group. The group sizes and the channel count are parameters; by default there are 40 channels and the mode selects a fixed group of 0, 2, 4 or 16 channels.

Top module: `txdma_chan_arb`

## Requirements
- R1: With mode 00 no channel is fixed; all requesting channels are granted in rotating order starting from the pointer, wrapping from channel 40 back to channel 1.
- R2: With mode 01 channels 1 and 2 form the fixed group; within it the lower channel number wins.
- R3: With mode 10 channels 1 to 4 form the fixed group, the lower channel number winning.
- R4: With mode 11 channels 1 to 16 form the fixed group, the lower channel number winning.
- R5: A request from any fixed-group channel wins over every request from the rotating group.
- R6: After a grant to a rotating-group channel the pointer moves to the channel just after it (wrapping); a grant to a fixed-group channel leaves the pointer unchanged, and the search skips fixed-group channels.
- R7: The grant is registered: it appears on the clock edge after a decision, is one-hot when grant_valid is 1, and stays unchanged while grant_valid is 1 until accept is pulsed; a decision is taken on every edge where grant_valid is 0 or accept is 1.
- R8: When a decision is taken with no request, grant_valid is 0, the grant is all zeros and the pointer does not move.
- R9: Synchronous reset clears the grant and sets the pointer to the lowest channel outside the fixed group of the mode present during reset; a later mode change does not reset the pointer.
- Encoding: request and grant bit i stands for channel i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_CH (40) | Request per channel, bit i = channel i+1 |
| mode | input | 2 | Fixed-group size select: 00 none, 01 two, 10 four, 11 sixteen |
| accept | input | 1 | Consumer takes the current grant, one-cycle pulse |
| gnt | output | N_CH (40) | Registered one-hot grant |
| gnt_vld | output | 1 | Grant vector holds a valid choice |

## Verification
The hardest state to reach from the ports is a pointer that sits in a known place inside the rotating group while fixed-group requests keep arriving, since only then does a grant to a fixed channel visibly leave the pointer alone. The bench gets there by resetting under a chosen mode to pin the pointer, walking it with single rotating grants, and then mixing a fixed request into the same request pattern, so the following rotating grant shows whether the pointer moved. Resetting under mode 01 and then switching to mode 00 likewise exposes that a mode change keeps the pointer.

// File: rtl/txdma_arb_pkg.sv
package txdma_arb_pkg;
   typedef enum logic [1:0] {
      ARB_ALL_ROTATE = 2'b00,
      ARB_FIX_SMALL  = 2'b01,
      ARB_FIX_MID    = 2'b10,
      ARB_FIX_LARGE  = 2'b11
   } arb_mode_e;
endpackage

// File: rtl/arb_fix_mask.sv
module arb_fix_mask #(
   parameter int N_CH  = 40,
   parameter int FIX_A = 2,
   parameter int FIX_B = 4,
   parameter int FIX_C = 16,
   localparam int IW   = $clog2(N_CH)
) (
   input  logic [1:0]      mode,
   output logic [N_CH-1:0] fix_mask,
   output logic [IW:0]     fix_n
);
   import txdma_arb_pkg::*;

   if (N_CH < 2) begin : g_bad_n
      $error("arb_fix_mask: N_CH must be at least 2");
   end
   if (!(FIX_A <= FIX_B && FIX_B <= FIX_C && FIX_C < N_CH)) begin : g_bad_fix
      $error("arb_fix_mask: fixed group sizes must grow and stay below N_CH");
   end

   always_comb begin
      unique case (arb_mode_e'(mode))
         ARB_ALL_ROTATE: fix_n = '0;
         ARB_FIX_SMALL:  fix_n = (IW+1)'(FIX_A);
         ARB_FIX_MID:    fix_n = (IW+1)'(FIX_B);
         ARB_FIX_LARGE:  fix_n = (IW+1)'(FIX_C);
         default:        fix_n = '0;
      endcase
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_mask
      assign fix_mask[g] = (fix_n > (IW+1)'(g));
   end
endmodule

// File: rtl/arb_low_find.sv
module arb_low_find #(
   parameter int N_CH = 40,
   localparam int IW  = $clog2(N_CH)
) (
   input  logic [N_CH-1:0] vec,
   output logic            any,
   output logic [IW-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
      any = |vec;
   end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int N_CH = 40,
   localparam int IW  = $clog2(N_CH)
) (
   input  logic [N_CH-1:0] vec,
   input  logic [IW-1:0]   ptr,
   output logic            any,
   output logic [IW-1:0]   idx
);
   logic [2*N_CH-1:0] dbl_sh;
   logic [N_CH-1:0]   rot;
   logic [IW-1:0]     pos;
   logic [IW:0]       sum;

   assign dbl_sh = {vec, vec} >> ptr;
   assign rot    = dbl_sh[N_CH-1:0];

   arb_low_find #(.N_CH(N_CH)) u_find (
      .vec (rot),
      .any (any),
      .idx (pos)
   );

   always_comb begin
      sum = {1'b0, ptr} + {1'b0, pos};
      if (sum >= (IW+1)'(N_CH)) idx = IW'(sum - (IW+1)'(N_CH));
      else                      idx = IW'(sum);
   end
endmodule

// File: rtl/txdma_chan_arb.sv
module txdma_chan_arb #(
   parameter int N_CH  = 40,
   parameter int FIX_A = 2,
   parameter int FIX_B = 4,
   parameter int FIX_C = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_CH-1:0] req,
   input  logic [1:0]      mode,
   input  logic            accept,
   output logic [N_CH-1:0] gnt,
   output logic            gnt_vld
);
   localparam int IW = $clog2(N_CH);
   localparam logic [N_CH-1:0] ONE = N_CH'(1);

   logic [N_CH-1:0] fix_mask, fix_req, rr_req;
   logic [IW:0]     fix_n;
   logic            fix_any, rr_any, win_any, update;
   logic [IW-1:0]   fix_idx, rr_idx, win_idx, rr_ptr;

   arb_fix_mask #(.N_CH(N_CH), .FIX_A(FIX_A), .FIX_B(FIX_B), .FIX_C(FIX_C)) u_mask (
      .mode     (mode),
      .fix_mask (fix_mask),
      .fix_n    (fix_n)
   );

   assign fix_req = req & fix_mask;
   assign rr_req  = req & ~fix_mask;

   arb_low_find #(.N_CH(N_CH)) u_fix (
      .vec (fix_req),
      .any (fix_any),
      .idx (fix_idx)
   );

   arb_rr_pick #(.N_CH(N_CH)) u_rr (
      .vec (rr_req),
      .ptr (rr_ptr),
      .any (rr_any),
      .idx (rr_idx)
   );

   assign update  = !gnt_vld || accept;
   assign win_any = fix_any || rr_any;
   assign win_idx = fix_any ? fix_idx : rr_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt     <= '0;
         gnt_vld <= 1'b0;
         rr_ptr  <= IW'(fix_n);
      end else if (update) begin
         gnt_vld <= win_any;
         gnt     <= win_any ? (ONE << win_idx) : '0;
         if (!fix_any && rr_any) begin
            rr_ptr <= (rr_idx == IW'(N_CH - 1)) ? '0 : rr_idx + 1'b1;
         end
      end
   end

   // R7
   gnt_shape_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(gnt) == (gnt_vld ? 1 : 0));

   // R7
   gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld && !accept |=> gnt_vld && $stable(gnt));

   // R7
   gnt_owned_chk: assert property (@(posedge clk) disable iff (rst)
      update && (|req) |=> gnt_vld && (|(gnt & $past(req))));

   // R5
   fix_first_chk: assert property (@(posedge clk) disable iff (rst)
      update && (|fix_req) |=> |(gnt & $past(fix_mask)));

   // R6
   ptr_keep_chk: assert property (@(posedge clk) disable iff (rst)
      update && (|fix_req) |=> $stable(rr_ptr));

   // R8
   idle_chk: assert property (@(posedge clk) disable iff (rst)
      update && !(|req) |=> !gnt_vld && $stable(rr_ptr));
endmodule

// File: tb/sim_txdma_chan_arb.sv
`timescale 1ns/1ps
module sim_txdma_chan_arb;
   localparam int N = 40;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] req = '0;
   logic [1:0]   mode = 2'b00;
   logic         accept = 1'b0;
   logic [N-1:0] gnt;
   logic         gnt_vld;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   txdma_chan_arb #(.N_CH(N)) u0 (
      .clk(clk), .rst(rst), .req(req), .mode(mode),
      .accept(accept), .gnt(gnt), .gnt_vld(gnt_vld)
   );

   function automatic logic [N-1:0] ch(int c);
      return N'(1) << (c - 1);
   endfunction

   task automatic check(string tag, logic [N-1:0] exp_g, logic exp_v);
      checks++;
      if (gnt !== exp_g || gnt_vld !== exp_v) begin
         errors++;
         $display("FAIL %s: gnt=%h vld=%b expected gnt=%h vld=%b",
                  tag, gnt, gnt_vld, exp_g, exp_v);
      end
   endtask

   task automatic do_reset(logic [1:0] m);
      @(negedge clk);
      rst = 1'b1; mode = m; req = '0; accept = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one decision from idle, check it, then retire it with accept
   task automatic grant_once(string tag, logic [N-1:0] r, int exp_ch);
      req = r;
      @(negedge clk);
      check(tag, ch(exp_ch), 1'b1);
      accept = 1'b1; req = '0;
      @(negedge clk);
      accept = 1'b0;
   endtask

   task automatic t_reset;
      do_reset(2'b00);
      check("R9 reset state", '0, 1'b0);
   endtask

   task automatic t_all_rotate;   // R1
      do_reset(2'b00);
      grant_once("R1 first", ch(1) | ch(3) | ch(40), 1);
      grant_once("R1 second", ch(1) | ch(3) | ch(40), 3);
      grant_once("R1 third", ch(1) | ch(3) | ch(40), 40);
      grant_once("R1 wrap", ch(1) | ch(3) | ch(40), 1);
   endtask

   task automatic t_mode_keep;    // R9
      do_reset(2'b01);
      mode = 2'b00;
      grant_once("R9 ptr kept on mode change", ch(2) | ch(3), 3);
   endtask

   task automatic t_fix_small;    // R2, R5, R6
      do_reset(2'b01);
      grant_once("R2 ch2 over ch5", ch(2) | ch(5), 2);
      grant_once("R2 ch1 over ch2", ch(1) | ch(2), 1);
      grant_once("R5 fixed over rotating", ch(2) | ch(3), 2);
      grant_once("R6 rotate ch3", ch(3) | ch(4), 3);
      grant_once("R6 fixed grant", ch(1) | ch(3) | ch(4), 1);
      grant_once("R6 ptr unmoved by fixed", ch(3) | ch(4), 4);
      grant_once("R6 wrap skips fixed", ch(3) | ch(4), 3);
   endtask

   task automatic t_fix_mid;      // R3
      do_reset(2'b10);
      grant_once("R3 ch4 over ch5", ch(4) | ch(5), 4);
      grant_once("R3 ch3 over ch4", ch(3) | ch(4), 3);
      grant_once("R3 rotating ch5", ch(5) | ch(40), 5);
   endtask

   task automatic t_fix_large;    // R4
      do_reset(2'b11);
      grant_once("R4 ch16 over ch17", ch(16) | ch(17), 16);
      grant_once("R4 ch10 over ch16", ch(10) | ch(16), 10);
      grant_once("R4 rotating ch17", ch(17) | ch(40), 17);
   endtask

   task automatic t_idle;         // R8
      do_reset(2'b00);
      grant_once("R8 setup ch5", ch(5), 5);
      repeat (4) @(negedge clk);
      check("R8 idle no grant", '0, 1'b0);
      grant_once("R8 ptr unchanged", ch(5) | ch(7), 7);
   endtask

   task automatic t_hold;         // R7
      do_reset(2'b00);
      req = ch(2);
      @(negedge clk);
      check("R7 grant registered", ch(2), 1'b1);
      req = ch(9);
      repeat (3) @(negedge clk);
      check("R7 held without accept", ch(2), 1'b1);
      accept = 1'b1;
      @(negedge clk);
      accept = 1'b0;
      check("R7 new decision on accept", ch(9), 1'b1);
      accept = 1'b1; req = '0;
      @(negedge clk);
      accept = 1'b0;
      check("R7 R8 cleared after accept", '0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_all_rotate();
      t_mode_keep();
      t_fix_small();
      t_fix_mid();
      t_fix_large();
      t_idle();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule